// File: doc/BRIEF.md
# Two-Entry Decoupling Queue

This block is a small synchronous queue that sits between a producing pipeline and a consuming unit on the same clock. Its job is to cut the combinational chain between the two sides' flow control. The producer offers words with a valid/ready handshake and is told only whether the queue has room. The consumer is told only whether the queue holds a word, and sees the oldest stored word on its data output.

Producer ready comes purely from registered occupancy. It never depends on the consumer's ready input. With the default two slots the queue still moves one word per clock when both sides stay active. A word can leave from one slot while the next word lands in the other. The number of slots is a parameter, with a minimum of two. Occupancy is held as a write pointer, a read pointer and a count. A synchronous reset empties the queue.

Top module: `decq_top`

## Requirements
- R1: `in_ready` is high exactly when fewer than DEPTH words are stored. It is decided by state registered at the last clock edge, so changing `out_ready` never changes `in_ready` within a cycle.
- R2: `out_valid` is high exactly when at least one word is stored. While it is high, `out_data` carries the oldest stored word.
- R3: The stored count never exceeds DEPTH. A word offered while `in_ready` is low is not captured and never appears at the output.
- R4: A cycle with both an accepted push and an accepted pop leaves the count unchanged. It keeps first-in first-out order.
- R5: Under any mix of valid and ready patterns, words leave in the order they entered. No word is lost and none is duplicated.
- R6: With `in_valid` and `out_ready` held high from an empty queue, `out_valid` is high on every cycle after the first. One word is delivered per cycle.
- R7: A cycle with `rst` high empties the queue. After that edge `out_valid` is low and `in_ready` is high, whatever was stored before.
- R8: `out_ready` while the queue is empty has no effect. The count stays zero and the next word pushed is the next word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Queue has a free slot |
| in_data | input | WIDTH | Word offered by the producer |
| out_valid | output | 1 | Queue holds at least one word |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | WIDTH | Oldest stored word |

## Verification
A short hand-computed sequence walks the queue through several states in turn: empty, half full, full, a push offered while full, a simultaneous push and pop, and a pop on empty. Raising `out_ready` while the queue is full separates a registered producer ready from one that leaks the consumer's ready. Holding both sides active from empty shows whether one word moves every cycle, which a ping-pong single-slot design would fail. Long random valid/ready patterns, checked against a queue model, expose reordering, loss or duplication. A reset in the middle of a fill shows that stale words are discarded.

// File: rtl/decq_pkg.sv
package decq_pkg;

    parameter int unsigned DECQ_MIN_DEPTH = 2;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/decq_ctrl.sv
module decq_ctrl
    import decq_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic             pop_ready,
    output logic             push_ready,
    output logic             pop_valid,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    occ_e   occ;
    logic   push, pop;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Flags come only from registered occupancy
    always_comb begin
        if (st_q.cnt == '0)           occ = OCC_EMPTY;
        else if (st_q.cnt == CNT_FULL) occ = OCC_FULL;
        else                          occ = OCC_PARTIAL;
    end

    assign push_ready = (occ != OCC_FULL);
    assign pop_valid  = (occ != OCC_EMPTY);

    always_comb begin
        st_d = st_q;
        push = push_valid & push_ready;
        pop  = pop_ready & pop_valid;
        if (push) st_d.wr_ptr = ptr_step(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = ptr_step(st_q.rd_ptr);
        unique case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_en  = push;
    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_FULL); // R3

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready && !(pop_ready && pop_valid))
        |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R3

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready && pop_ready && pop_valid)
        |=> st_q.cnt == $past(st_q.cnt)); // R4

    AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!pop_valid && !push_valid) |=> !pop_valid); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (!pop_valid && push_ready)); // R7

endmodule

// File: rtl/decq_store.sv
module decq_store #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 2,
    parameter int unsigned PTR_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot_d [DEPTH];
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = (wr_en && (wr_ptr == PTR_W'(i))) ? wr_data : slot_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= slot_d[i];
        end
    end

    assign rd_data = slot_q[rd_ptr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot_q[$past(wr_ptr)] == $past(wr_data)); // R5

endmodule

// File: rtl/decq_top.sv
module decq_top
    import decq_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    generate
        if (DEPTH < DECQ_MIN_DEPTH) begin : g_depth_bad
            $error("decq_top: DEPTH must be at least 2");
        end
    endgenerate

    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    decq_ctrl #(
        .DEPTH(DEPTH)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_valid(in_valid),
        .pop_ready (out_ready),
        .push_ready(in_ready),
        .pop_valid (out_valid),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr)
    );

    decq_store #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH),
        .PTR_W(PTR_W)
    ) i_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr),
        .wr_data(in_data),
        .rd_ptr (rd_ptr),
        .rd_data(out_data)
    );

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R2

endmodule

// File: tb/test_decq_top.sv
module test_decq_top;

    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int NVEC  = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    decq_top #(.WIDTH(W), .DEPTH(2)) i_decq_top (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // {in_valid, out_ready, in_data, exp in_ready, exp out_valid, exp out_data}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'h12, 1'b1, 1'b1, 8'h11},
        {1'b1, 1'b0, 8'h13, 1'b0, 1'b1, 8'h11}, // R3 offer while full
        {1'b1, 1'b1, 8'h14, 1'b0, 1'b1, 8'h11}, // R1 out_ready cannot lift in_ready
        {1'b1, 1'b1, 8'h15, 1'b1, 1'b1, 8'h12}, // R4 push and pop together
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h15},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00}, // R8 pop on empty
        {1'b1, 1'b1, 8'h16, 1'b1, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'h17, 1'b1, 1'b1, 8'h16},
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h17},
        {1'b1, 1'b0, 8'h18, 1'b1, 1'b1, 8'h17},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h17},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h18},
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] model [$];
        int pushed;
        int popped;
        bit exp_ir, exp_ov;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R7 reset in_ready", in_ready, 1);

        // Table walk: inputs set just after the falling edge, outputs read 1 time unit later
        for (int k = 0; k < NVEC; k++) begin
            if (k != 0) @(negedge clk);
            in_valid  = VEC[k][19];
            out_ready = VEC[k][18];
            in_data   = VEC[k][17:10];
            #1;
            chk(in_ready == VEC[k][9], "R1 in_ready", in_ready, VEC[k][9]);
            chk(out_valid == VEC[k][8], "R2 out_valid", out_valid, VEC[k][8]);
            if (VEC[k][8])
                chk(out_data == VEC[k][7:0], "R5 head data", out_data, VEC[k][7:0]);
        end

        // R6: both sides always active from empty
        do_reset();
        for (int k = 0; k < 32; k++) begin
            if (k != 0) @(negedge clk);
            in_valid = 1'b1; out_ready = 1'b1; in_data = W'(8'h40 + k);
            #1;
            chk(in_ready == 1'b1, "R6 in_ready", in_ready, 1);
            if (k == 0)
                chk(out_valid == 1'b0, "R6 first cycle", out_valid, 0);
            else begin
                chk(out_valid == 1'b1, "R6 out_valid", out_valid, 1);
                chk(out_data == W'(8'h40 + k - 1), "R6 data", out_data, 8'h40 + k - 1);
            end
        end

        // R5: random patterns against a queue model
        do_reset();
        pushed = 0; popped = 0;
        for (int k = 0; k < 4000; k++) begin
            if (k != 0) @(negedge clk);
            in_valid  = (k < 3000) ? ($urandom_range(0, 3) != 0) : 1'b0;
            out_ready = (k < 3000) ? ($urandom_range(0, 2) != 0) : 1'b1;
            in_data   = W'($urandom);
            #1;
            exp_ir = (model.size() < 2);
            exp_ov = (model.size() > 0);
            chk(in_ready == exp_ir, "R1 random in_ready", in_ready, exp_ir);
            chk(out_valid == exp_ov, "R2 random out_valid", out_valid, exp_ov);
            if (exp_ov && out_ready) begin
                chk(out_data == model[0], "R5 random order", out_data, model[0]);
                void'(model.pop_front());
                popped++;
            end
            if (exp_ir && in_valid) begin
                model.push_back(in_data);
                pushed++;
            end
        end
        chk(popped == pushed, "R5 no loss or duplication", popped, pushed);

        // R7: reset while holding two words
        do_reset();
        @(negedge clk); in_valid = 1'b1; in_data = 8'hA1;
        @(negedge clk); in_data = 8'hA2;
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R7 flush out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R7 flush in_ready", in_ready, 1);

        // R8: pops on empty leave nothing behind
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R8 still empty", out_valid, 0);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h5C;
        @(negedge clk); in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b1, "R8 one word", out_valid, 1);
        chk(out_data == 8'h5C, "R8 word intact", out_data, 8'h5C);
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R8 no duplicate", out_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule